// File: doc/BRIEF.md
# 16-bit ALU Execution Stage

This block is the execute stage for the arithmetic and logic instructions of a small 16-bit processor. An instruction belongs to this class when its top bit is set. Each cycle the stage takes one instruction word. It drives the two register-file read indexes from that word, and it receives the operand values in the same cycle. It then registers the result, the destination index, a write strobe and four condition flags: carry, overflow, negative and zero. The results appear after the next clock edge. A new instruction can be accepted on every clock.

The flags are kept inside the block. An add-with-carry or subtract-with-carry therefore sees the flags left by the instruction just before it, with no stall. The operand forms are an 8-bit immediate, three registers, and compare/test forms that only update flags. The block also covers single-bit shifts and rotates, barrel rotates left, byte sign extension and bitwise inversion. Fields that one form leaves unused are reused by other forms, so decoding depends on bits 11, 4, 3 and 2 as well as on the opcode bits 14..12.

Top module: `alu_exec`

## Requirements
- R1: While rst_ni is low, result_o, dst_o, we_o and all four flags are 0.
- R2: The immediate form has bit 15 = 1 and bit 11 = 1. Bits 14..12 choose 000 ADD, 001 SUB, 010 XOR, 011 XNOR, 100 OR, 101 ORN (A or not K), 110 AND, 111 ANDN (A and not K). Bits 10..8 name both the source and the destination register. Bits 7..0 are zero-extended to form K.
- R3: The register form has bit 11 = 0, bit 4 = 0 and bit 3 = 0. It writes Y = A op B, where Y is bits 10..8, A is bits 7..5 and B is bits 2..0. The op codes in bits 14..12 are the same as in R2.
- R4: With bit 11 = 0, bit 4 = 0 and bit 3 = 1, op 000 computes A+B+C and op 001 computes A+~B+C, where C is the current carry flag.
- R5: N is result bit 15, and Z is 1 exactly when the result is zero, for every operation. Add and subtract set C to the carry out, so that for a subtraction C = 1 means no borrow. They set V to the signed overflow. XOR, XNOR, OR, ORN, AND and ANDN leave C and V unchanged.
- R6: With bit 11 = 0, bit 4 = 0, bit 3 = 1 and op 010..111, the operation only sets flags and we_o stays 0. The ops are: 010 equality test (A xor B), 011 complement test (A xnor B), 100 add compare (A+B), 101 compare (A-B), 110 bit test (A and B), 111 inverted bit test (A and not B). A true equality, complement or compare test gives Z = 1. A true bit test, meaning a common bit is set, gives Z = 0.
- R7: With bit 11 = 0, bit 4 = 1 and op 010 (left) or 011 (right), the source A (bits 7..5) is shifted by one into Y (bits 10..8). Bit 2 = 1 selects the arithmetic shift, which takes precedence over bit 3: right copies the MSB, and left is the plain shift. Otherwise bit 3 = 1 rotates through C. Otherwise the vacated bit is filled with 0. C takes the bit shifted out, and V is unchanged.
- R8: With bit 4 = 1, op 101 rotates A left by bits 3..0, and op 100 rotates A left by the low 4 bits of register B (bits 2..0). C and V are unchanged.
- R9: With bit 4 = 1, op 000/001 copies A bit 7 into bits 15..8, and op 110/111 inverts all bits of A. Both write to Y.
- R10: The outputs of an instruction appear after the first rising edge at which it is presented. Instructions presented on consecutive clocks each take effect, and a with-carry operation uses the flags produced by the instruction one clock earlier.
- R11: When bit 15 = 0 or valid_i is low, the next clock leaves we_o at 0 and all flags unchanged.
- R12: ra_o is bits 10..8 for the immediate form and bits 7..5 otherwise. rb_o is bits 2..0. Both are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is present this cycle |
| instr_i | input | 16 | Instruction word |
| ra_o | output | 3 | Register-file read index for operand A |
| rb_o | output | 3 | Register-file read index for operand B |
| a_i | input | DATA_W | Value of register ra_o |
| b_i | input | DATA_W | Value of register rb_o |
| result_o | output | DATA_W | Registered result |
| dst_o | output | 3 | Registered destination index |
| we_o | output | 1 | Registered register-file write strobe |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |

## Verification
The bench builds the block with the default DATA_W of 16, the width the instruction encoding assumes. At this width the rotate field reaches every amount from 0 to 15, the 8-bit constant is zero-extended into the upper byte, and bit 15 marks the sign for both the overflow and the negative flag. A bench-side register file with fixed contents supplies the operands. This makes chains of with-carry and flag-only instructions depend on the flag values each step leaves behind.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  typedef enum logic [2:0] {
    FU_ADD, FU_LOGIC, FU_SHIFT, FU_ROT, FU_SEXT, FU_INV
  } fu_e;

  typedef struct packed {
    fu_e        fu;
    logic       use_imm;
    logic       inv_b;     // subtract / ~B logic forms
    logic       use_cin;   // carry flag instead of inv_b as carry-in
    logic [1:0] lsel;      // 01 xor, 10 or, 11 and
    logic       sh_right;
    logic       sh_rot;
    logic       sh_arith;
    logic       rot_imm;
    logic       wr;
    logic       upd_c;
    logic       upd_v;
  } alu_ctl_t;

  typedef struct packed {
    logic c;
    logic v;
    logic n;
    logic z;
  } alu_flags_t;

endpackage

// File: rtl/alu_dec.sv
module alu_dec
  import alu_exec_pkg::*;
(
  input  logic       alu_i,
  input  logic [2:0] op_i,
  input  logic       imm_i,
  input  logic       f4_i,
  input  logic       f3_i,
  input  logic       f2_i,
  output alu_ctl_t   ctl_o
);

  always_comb begin
    ctl_o         = '0;
    ctl_o.fu      = FU_ADD;
    ctl_o.use_imm = imm_i;
    if (alu_i) begin
      if (imm_i || !f4_i) begin
        ctl_o.inv_b = op_i[0];
        if (op_i[2:1] == 2'b00) begin
          ctl_o.use_cin = !imm_i && f3_i;
          ctl_o.wr      = 1'b1;
          ctl_o.upd_c   = 1'b1;
          ctl_o.upd_v   = 1'b1;
        end else if (!imm_i && f3_i) begin
          // flag-only tests; 100/101 borrow the adder
          if (op_i[2:1] == 2'b10) begin
            ctl_o.upd_c = 1'b1;
            ctl_o.upd_v = 1'b1;
          end else begin
            ctl_o.fu   = FU_LOGIC;
            ctl_o.lsel = op_i[2:1];
          end
        end else begin
          ctl_o.fu   = FU_LOGIC;
          ctl_o.lsel = op_i[2:1];
          ctl_o.wr   = 1'b1;
        end
      end else begin
        ctl_o.wr = 1'b1;
        unique case (op_i)
          3'b000, 3'b001: ctl_o.fu = FU_SEXT;
          3'b010, 3'b011: begin
            ctl_o.fu       = FU_SHIFT;
            ctl_o.sh_right = op_i[0];
            ctl_o.sh_arith = f2_i;
            ctl_o.sh_rot   = f3_i && !f2_i;
            ctl_o.upd_c    = 1'b1;
          end
          3'b100, 3'b101: begin
            ctl_o.fu      = FU_ROT;
            ctl_o.rot_imm = op_i[0];
          end
          default: ctl_o.fu = FU_INV;
        endcase
      end
    end
  end

endmodule

// File: rtl/alu_rot.sv
module alu_rot #(
  parameter int W = 16
) (
  input  logic [W-1:0]         d_i,
  input  logic [$clog2(W)-1:0] amt_i,
  output logic [W-1:0]         q_o
);

  localparam int SH_W = $clog2(W);

  logic [W-1:0] stg [SH_W+1];

  assign stg[0] = d_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int D = 2 ** s;
    assign stg[s+1] = amt_i[s] ? {stg[s][W-1-D:0], stg[s][W-1:W-D]} : stg[s];
  end

  assign q_o = stg[SH_W];

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_exec_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_ctl_t     ctl_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [7:0]   imm8_i,
  input  logic [3:0]   rimm_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o
);

  localparam int SH_W = $clog2(W);

  logic [W-1:0]    opb, bb, rot_q;
  logic [W:0]      sum;
  logic            cin;
  logic [SH_W-1:0] rot_amt;

  assign opb     = ctl_i.use_imm ? {{(W-8){1'b0}}, imm8_i} : b_i;
  assign bb      = ctl_i.inv_b ? ~opb : opb;
  assign cin     = ctl_i.use_cin ? c_i : ctl_i.inv_b;
  assign sum     = {1'b0, a_i} + {1'b0, bb} + {{W{1'b0}}, cin};
  assign rot_amt = ctl_i.rot_imm ? SH_W'(rimm_i) : b_i[SH_W-1:0];

  alu_rot #(.W(W)) u_rot (
    .d_i   (a_i),
    .amt_i (rot_amt),
    .q_o   (rot_q)
  );

  always_comb begin
    res_o = sum[W-1:0];
    c_o   = sum[W];
    v_o   = (a_i[W-1] == bb[W-1]) && (sum[W-1] != a_i[W-1]);
    unique case (ctl_i.fu)
      FU_LOGIC: begin
        unique case (ctl_i.lsel)
          2'b01:   res_o = a_i ^ bb;
          2'b10:   res_o = a_i | bb;
          default: res_o = a_i & bb;
        endcase
      end
      FU_SHIFT: begin
        if (ctl_i.sh_right) begin
          res_o = {ctl_i.sh_arith ? a_i[W-1] : (ctl_i.sh_rot & c_i), a_i[W-1:1]};
          c_o   = a_i[0];
        end else begin
          res_o = {a_i[W-2:0], ctl_i.sh_rot & c_i};
          c_o   = a_i[W-1];
        end
      end
      FU_ROT:  res_o = rot_q;
      FU_SEXT: res_o = {{(W-8){a_i[7]}}, a_i[7:0]};
      FU_INV:  res_o = ~a_i;
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [15:0]       instr_i,
  output logic [2:0]        ra_o,
  output logic [2:0]        rb_o,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic [2:0]        dst_o,
  output logic              we_o,
  output logic              flag_c_o,
  output logic              flag_v_o,
  output logic              flag_n_o,
  output logic              flag_z_o
);

  logic              exec;
  alu_ctl_t          ctl;
  alu_flags_t        flg_q;
  logic [DATA_W-1:0] res;
  logic              c_nx, v_nx;

  assign exec = valid_i && instr_i[15];
  assign ra_o = instr_i[11] ? instr_i[10:8] : instr_i[7:5];
  assign rb_o = instr_i[2:0];

  alu_dec u_dec (
    .alu_i (exec),
    .op_i  (instr_i[14:12]),
    .imm_i (instr_i[11]),
    .f4_i  (instr_i[4]),
    .f3_i  (instr_i[3]),
    .f2_i  (instr_i[2]),
    .ctl_o (ctl)
  );

  alu_datapath #(.W(DATA_W)) u_dp (
    .ctl_i  (ctl),
    .a_i    (a_i),
    .b_i    (b_i),
    .imm8_i (instr_i[7:0]),
    .rimm_i (instr_i[3:0]),
    .c_i    (flg_q.c),
    .res_o  (res),
    .c_o    (c_nx),
    .v_o    (v_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      dst_o    <= '0;
      we_o     <= 1'b0;
      flg_q    <= '0;
    end else begin
      we_o <= ctl.wr;
      if (exec) begin
        result_o <= res;
        dst_o    <= instr_i[10:8];
        flg_q.n  <= res[DATA_W-1];
        flg_q.z  <= (res == '0);
        if (ctl.upd_c) flg_q.c <= c_nx;
        if (ctl.upd_v) flg_q.v <= v_nx;
      end
    end
  end

  assign flag_c_o = flg_q.c;
  assign flag_v_o = flg_q.v;
  assign flag_n_o = flg_q.n;
  assign flag_z_o = flg_q.z;

  // R11
  idle_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && instr_i[15]) |=> !we_o);

  // R11
  idle_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && instr_i[15]) |=> $stable({flag_c_o, flag_v_o, flag_n_o, flag_z_o}));

  // R6
  test_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[15] && !instr_i[11] && !instr_i[4] && instr_i[3] &&
     instr_i[14:13] != 2'b00) |=> !we_o);

  // R5
  logic_cv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[15] && (instr_i[11] || !instr_i[4]) && instr_i[14:13] != 2'b00 &&
     !(!instr_i[11] && instr_i[3] && instr_i[14:13] == 2'b10))
    |=> ($stable(flag_c_o) && $stable(flag_v_o)));

  // R2
  imm_dst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[15] && instr_i[11]) |=> (we_o && dst_o == $past(instr_i[10:8])));

  // R5
  zero_tracks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (flag_z_o == (result_o == '0)));

endmodule

// File: tb/test_alu_exec.sv
module test_alu_exec;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [2:0]  ra_o, rb_o, dst_o;
  logic [15:0] a_i, b_i, result_o;
  logic        we_o, flag_c_o, flag_v_o, flag_n_o, flag_z_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [15:0] rf [8];

  always #10 clk_i = ~clk_i;

  always_comb begin
    a_i = rf[ra_o];
    b_i = rf[rb_o];
  end

  alu_exec i_alu_exec (
    .clk_i, .rst_ni, .valid_i, .instr_i, .ra_o, .rb_o, .a_i, .b_i,
    .result_o, .dst_o, .we_o, .flag_c_o, .flag_v_o, .flag_n_o, .flag_z_o
  );

  function automatic logic [15:0] fimm(input logic [2:0] op, input logic [2:0] r, input logic [7:0] k);
    return {1'b1, op, 1'b1, r, k};
  endfunction

  function automatic logic [15:0] freg(input logic [2:0] op, input logic [2:0] y,
                                       input logic [2:0] a, input logic b3, input logic [2:0] b);
    return {1'b1, op, 1'b0, y, a, 1'b0, b3, b};
  endfunction

  function automatic logic [15:0] fun(input logic [2:0] op, input logic [2:0] d,
                                      input logic [2:0] s, input logic [3:0] low);
    return {1'b1, op, 1'b0, d, s, 1'b1, low};
  endfunction

  // exp_f = {C,V,N,Z}
  task automatic step(input logic [15:0] ins, input logic v, input logic ewe,
                      input logic [2:0] edst, input logic [15:0] eres,
                      input logic [3:0] ef, input string tag);
    logic [3:0] af;
    @(negedge clk_i);
    instr_i = ins;
    valid_i = v;
    @(posedge clk_i);
    #1;
    af = {flag_c_o, flag_v_o, flag_n_o, flag_z_o};
    checks++;
    if (we_o !== ewe || af !== ef || (ewe && (result_o !== eres || dst_o !== edst))) begin
      failures++;
      $display("FAIL %s: we=%b dst=%0d res=%h flags=%b expected we=%b dst=%0d res=%h flags=%b",
               tag, we_o, dst_o, result_o, af, ewe, edst, eres, ef);
    end
  endtask

  task automatic t_reset;
    checks++;
    if (result_o !== 16'h0 || dst_o !== 3'd0 || we_o !== 1'b0 ||
        {flag_c_o, flag_v_o, flag_n_o, flag_z_o} !== 4'b0000) begin
      failures++;
      $display("FAIL R1: res=%h dst=%0d we=%b flags=%b expected all 0", result_o, dst_o, we_o,
               {flag_c_o, flag_v_o, flag_n_o, flag_z_o});
    end
  endtask

  task automatic probe(input logic [15:0] ins, input logic [2:0] era, input logic [2:0] erb);
    @(negedge clk_i);
    instr_i = ins;
    valid_i = 1'b0;
    #1;
    checks++;
    if (ra_o !== era || rb_o !== erb) begin
      failures++;
      $display("FAIL R12: ra=%0d rb=%0d expected ra=%0d rb=%0d", ra_o, rb_o, era, erb);
    end
  endtask

  task automatic t_index;
    probe(fimm(3'b000, 3'd3, 8'h25), 3'd3, 3'd5);   // R12 immediate
    probe(freg(3'b010, 3'd1, 3'd5, 1'b0, 3'd6), 3'd5, 3'd6);
  endtask

  task automatic t_imm;  // R2, R5 (C held at 1 across logic ops)
    step(fimm(3'b000, 3'd0, 8'hFF), 1, 1, 3'd0, 16'h1333, 4'b0000, "R2 ADDi");
    step(fimm(3'b001, 3'd5, 8'h01), 1, 1, 3'd5, 16'h0000, 4'b1001, "R2 SUBi");
    step(fimm(3'b010, 3'd6, 8'hFF), 1, 1, 3'd6, 16'h0FF0, 4'b1000, "R2 XORi");
    step(fimm(3'b011, 3'd1, 8'hFF), 1, 1, 3'd1, 16'hFFFF, 4'b1010, "R2 XNORi");
    step(fimm(3'b100, 3'd2, 8'h01), 1, 1, 3'd2, 16'h8001, 4'b1010, "R2 ORi");
    step(fimm(3'b101, 3'd0, 8'hFF), 1, 1, 3'd0, 16'hFF34, 4'b1010, "R2 ORNi");
    step(fimm(3'b110, 3'd4, 8'h80), 1, 1, 3'd4, 16'h0080, 4'b1000, "R5 ANDi");
    step(fimm(3'b111, 3'd6, 8'h0F), 1, 1, 3'd6, 16'h0F00, 4'b1000, "R5 ANDNi");
  endtask

  task automatic t_reg;
    step(freg(3'b000, 3'd1, 3'd3, 1'b0, 3'd5), 1, 1, 3'd1, 16'h8000, 4'b0110, "R3 ADD ovf");
    step(freg(3'b001, 3'd2, 3'd5, 1'b0, 3'd7), 1, 1, 3'd2, 16'hFFFE, 4'b0010, "R5 SUB borrow");
    step(freg(3'b000, 3'd3, 3'd4, 1'b1, 3'd5), 1, 1, 3'd3, 16'h0000, 4'b1001, "R4 ADDC c0");
    step(freg(3'b000, 3'd0, 3'd0, 1'b1, 3'd5), 1, 1, 3'd0, 16'h1236, 4'b0000, "R10 ADDC c1");
    step(freg(3'b001, 3'd0, 3'd5, 1'b1, 3'd5), 1, 1, 3'd0, 16'hFFFF, 4'b0010, "R4 SUBC c0");
    step(freg(3'b110, 3'd7, 3'd6, 1'b0, 3'd4), 1, 1, 3'd7, 16'h0F0F, 4'b0000, "R3 AND");
    step(freg(3'b011, 3'd1, 3'd0, 1'b0, 3'd0), 1, 1, 3'd1, 16'hFFFF, 4'b0010, "R3 XNOR");
  endtask

  task automatic t_tests;  // R6
    step(freg(3'b010, 3'd0, 3'd0, 1'b1, 3'd0), 1, 0, 3'd0, 16'h0, 4'b0001, "R6 TEQ eq");
    step(freg(3'b011, 3'd0, 3'd2, 1'b1, 3'd3), 1, 0, 3'd0, 16'h0, 4'b0001, "R6 TCM");
    step(freg(3'b101, 3'd0, 3'd5, 1'b1, 3'd7), 1, 0, 3'd0, 16'h0, 4'b0010, "R6 CMP lt");
    step(freg(3'b101, 3'd0, 3'd7, 1'b1, 3'd5), 1, 0, 3'd0, 16'h0, 4'b1000, "R6 CMP gt");
    step(freg(3'b100, 3'd0, 3'd4, 1'b1, 3'd5), 1, 0, 3'd0, 16'h0, 4'b1001, "R6 CMN");
    step(freg(3'b110, 3'd0, 3'd6, 1'b1, 3'd1), 1, 0, 3'd0, 16'h0, 4'b1000, "R6 TST true");
    step(freg(3'b110, 3'd0, 3'd6, 1'b1, 3'd2), 1, 0, 3'd0, 16'h0, 4'b1001, "R6 TST false");
    step(freg(3'b111, 3'd0, 3'd6, 1'b1, 3'd6), 1, 0, 3'd0, 16'h0, 4'b1001, "R6 TIB zero");
    step(freg(3'b111, 3'd0, 3'd4, 1'b1, 3'd6), 1, 0, 3'd0, 16'h0, 4'b1010, "R6 TIB set");
  endtask

  task automatic t_shift;  // R7
    step(fun(3'b010, 3'd1, 3'd2, 4'b0000), 1, 1, 3'd1, 16'h0000, 4'b1001, "R7 SHL");
    step(fun(3'b011, 3'd1, 3'd5, 4'b0000), 1, 1, 3'd1, 16'h0000, 4'b1001, "R7 SHR lsb");
    step(fun(3'b011, 3'd1, 3'd6, 4'b0000), 1, 1, 3'd1, 16'h0787, 4'b1000, "R7 SHR");
    step(fun(3'b010, 3'd1, 3'd3, 4'b1000), 1, 1, 3'd1, 16'hFFFF, 4'b0010, "R7 ROLC");
    step(fun(3'b011, 3'd1, 3'd7, 4'b1000), 1, 1, 3'd1, 16'h0001, 4'b1000, "R7 RORC c0");
    step(fun(3'b011, 3'd1, 3'd4, 4'b1000), 1, 1, 3'd1, 16'hFFFF, 4'b1010, "R7 RORC c1");
    step(fun(3'b010, 3'd1, 3'd4, 4'b1100), 1, 1, 3'd1, 16'hFFFE, 4'b1010, "R7 ASHL prec");
    step(fun(3'b011, 3'd1, 3'd2, 4'b0100), 1, 1, 3'd1, 16'hC000, 4'b0010, "R7 ASHR");
    step(fun(3'b010, 3'd1, 3'd3, 4'b0100), 1, 1, 3'd1, 16'hFFFE, 4'b0010, "R7 ASHL");
  endtask

  task automatic t_rot;  // R8
    step(fun(3'b101, 3'd2, 3'd0, 4'd4),    1, 1, 3'd2, 16'h2341, 4'b0000, "R8 ROTi 4");
    step(fun(3'b101, 3'd2, 3'd0, 4'd0),    1, 1, 3'd2, 16'h1234, 4'b0000, "R8 ROTi 0");
    step(fun(3'b101, 3'd2, 3'd0, 4'd15),   1, 1, 3'd2, 16'h091A, 4'b0000, "R8 ROTi 15");
    step(fun(3'b100, 3'd2, 3'd6, 4'b1111), 1, 1, 3'd2, 16'h7878, 4'b0000, "R8 ROT r7");
    step(fun(3'b100, 3'd2, 3'd0, 4'b0100), 1, 1, 3'd2, 16'h091A, 4'b0000, "R8 ROT low4");
  endtask

  task automatic t_unary;  // R9
    step(fun(3'b000, 3'd3, 3'd1, 4'h0), 1, 1, 3'd3, 16'hFFFF, 4'b0010, "R9 BSE neg");
    step(fun(3'b001, 3'd3, 3'd6, 4'hF), 1, 1, 3'd3, 16'h000F, 4'b0000, "R9 BSE pos");
    step(fun(3'b110, 3'd4, 3'd0, 4'h0), 1, 1, 3'd4, 16'hEDCB, 4'b0010, "R9 INV");
    step(fun(3'b111, 3'd4, 3'd4, 4'h0), 1, 1, 3'd4, 16'h0000, 4'b0001, "R9 INV zero");
  endtask

  task automatic t_idle;  // R11
    step(16'h1234, 1, 0, 3'd0, 16'h0, 4'b0001, "R11 non-ALU");
    step(fimm(3'b000, 3'd4, 8'h01), 0, 0, 3'd0, 16'h0, 4'b0001, "R11 invalid");
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 5000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected < 5000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rf[0] = 16'h1234; rf[1] = 16'h00FF; rf[2] = 16'h8000; rf[3] = 16'h7FFF;
    rf[4] = 16'hFFFF; rf[5] = 16'h0001; rf[6] = 16'h0F0F; rf[7] = 16'h0003;
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_index();
    t_imm();
    t_reg();
    t_tests();
    t_shift();
    t_rot();
    t_unary();
    t_idle();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule